// File: doc/BRIEF.md
# Level-Sensitive Interrupt Controller

This block gathers 32 level-sensitive interrupt request lines and decides, at each instruction boundary reported by a simple in-order CPU, whether that CPU must leave its program for the exception handler. Each request is qualified by its own bit in a software-writable mask and by a global enable bit held in bit 0 of a status word. When an exception is taken, the controller records the address at which the program should resume, keeps a copy of the status word and clears the global enable. Further requests therefore wait until software turns interrupts back on.

The scheme is non-vectored. Every source leads to the same handler address, which is a build-time parameter. The handler finds out which line is asking by reading the pending register, which is the live AND of the request levels and the mask. A request is dropped only by silencing it at the device. The return-from-exception strobe copies the saved status word back, and the saved resume address is always available on an output for the CPU to branch to.

Top module: `irq_gate_ctrl`

## Requirements
- R1: After reset the status word, the saved status word, the mask register and the saved resume address are all 0, so no request is taken until software enables it.
- R2: Register select 3 reads the pending word, whose bit i is irq_lvl[i] AND mask bit i and which follows the inputs in the same cycle. A write to select 3 changes no register.
- R3: Register select 2 is the mask register. It can be written and read in full, and mask bit i alone gates source i.
- R4: exc_take is 1 in a cycle exactly when insn_done is 1, status bit 0 is 1, the pending word is nonzero and eret is 0.
- R5: exc_vector always carries the single handler address HANDLER_ADDR (default 0x20), whichever source caused the exception.
- R6: In the cycle after exc_take, the saved status holds the previous status, status bit 0 is 0 with the other status bits kept, and the saved resume address equals the cur_pc of the taking cycle. A software write to select 0, 1 or 4 in the taking cycle is dropped.
- R7: While status bit 0 is 0, requests are never taken but remain visible in the pending word. The first insn_done after software sets bit 0 with a pending request takes the exception.
- R8: On eret, the status word takes the value of the saved status in the next cycle, and this beats a software write to select 0 in the same cycle. resume_pc always shows the saved resume address.
- R9: Select 0 (status), select 1 (saved status) and select 4 (saved resume address) can be written and read in full. Selects 5 to 7 read as 0, and writes to them change nothing.
- R10: No exception is taken in a cycle with insn_done at 0, whatever the request and enable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lvl | input | 32 | Level-sensitive request lines, bit i for source i |
| insn_done | input | 1 | Instruction-complete strobe from the CPU |
| cur_pc | input | 32 | Address at which the program resumes if interrupted now |
| eret | input | 1 | Return-from-exception strobe |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0 status, 1 saved status, 2 mask, 3 pending, 4 resume address) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_sel, combinational |
| exc_take | output | 1 | Take the exception at this boundary |
| exc_vector | output | 32 | Handler address |
| resume_pc | output | 32 | Saved resume address for return from exception |

## Verification
The bench goes after collisions at the boundary. In one, a status write lands in the same cycle as exception entry; a design that let the write win would leave interrupts enabled inside the handler and nest without limit. In another, eret arrives together with insn_done while a request is pending; a design that took the exception there would overwrite the saved state of the handler it is leaving. The bench also holds requests while the global enable is 0 and then re-enables. A design that latched or lost edges would either take a stale request after the device dropped it or miss one that is still asserted. Writes to the read-only pending word and to unused selects are followed by read-back, so a decoder that aliases addresses shows up.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
    localparam int unsigned SEL_W   = 3;
    localparam int unsigned GIE_BIT = 0;

    typedef enum logic [SEL_W-1:0] {
        SEL_STATUS  = 3'd0,
        SEL_ESTATUS = 3'd1,
        SEL_MASK    = 3'd2,
        SEL_PEND    = 3'd3,
        SEL_EPC     = 3'd4
    } reg_sel_e;
endpackage

// File: rtl/irq_pending.sv
module irq_pending #(
    parameter int unsigned N_SRC = 32
) (
    input  logic [N_SRC-1:0] lvl,
    input  logic [N_SRC-1:0] mask,
    output logic [N_SRC-1:0] pend,
    output logic             any_pend
);
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        assign pend[i] = lvl[i] & mask[i];
    end
    assign any_pend = |pend;
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned N_SRC = 32,
    parameter int unsigned XLEN  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             eret,
    input  logic [XLEN-1:0]  cur_pc,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [XLEN-1:0]  wr_data,
    output logic [XLEN-1:0]  status,
    output logic [XLEN-1:0]  estatus,
    output logic [XLEN-1:0]  epc,
    output logic [N_SRC-1:0] mask
);
    typedef struct packed {
        logic [XLEN-1:0]  status;
        logic [XLEN-1:0]  estatus;
        logic [XLEN-1:0]  epc;
        logic [N_SRC-1:0] mask;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wr_sel)
                SEL_STATUS:  st_d.status  = wr_data;
                SEL_ESTATUS: st_d.estatus = wr_data;
                SEL_MASK:    st_d.mask    = wr_data[N_SRC-1:0];
                SEL_EPC:     st_d.epc     = wr_data;
                default:     ;
            endcase
        end
        if (take) begin
            st_d.estatus          = st_q.status;
            st_d.status           = st_q.status;
            st_d.status[GIE_BIT]  = 1'b0;
            st_d.epc              = cur_pc;
        end else if (eret) begin
            st_d.status = st_q.estatus;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status  = st_q.status;
    assign estatus = st_q.estatus;
    assign epc     = st_q.epc;
    assign mask    = st_q.mask;
endmodule

// File: rtl/irq_rdmux.sv
module irq_rdmux
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned N_SRC = 32,
    parameter int unsigned XLEN  = 32
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [XLEN-1:0]  status,
    input  logic [XLEN-1:0]  estatus,
    input  logic [XLEN-1:0]  epc,
    input  logic [N_SRC-1:0] mask,
    input  logic [N_SRC-1:0] pend,
    output logic [XLEN-1:0]  rdata
);
    always_comb begin
        rdata = '0;
        case (sel)
            SEL_STATUS:  rdata = status;
            SEL_ESTATUS: rdata = estatus;
            SEL_MASK:    rdata[N_SRC-1:0] = mask;
            SEL_PEND:    rdata[N_SRC-1:0] = pend;
            SEL_EPC:     rdata = epc;
            default:     rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned     N_SRC        = 32,
    parameter int unsigned     XLEN         = 32,
    parameter logic [XLEN-1:0] HANDLER_ADDR = 32'h0000_0020
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] irq_lvl,
    input  logic             insn_done,
    input  logic [XLEN-1:0]  cur_pc,
    input  logic             eret,
    input  logic             reg_we,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic [XLEN-1:0]  reg_wdata,
    output logic [XLEN-1:0]  reg_rdata,
    output logic             exc_take,
    output logic [XLEN-1:0]  exc_vector,
    output logic [XLEN-1:0]  resume_pc
);
    logic [XLEN-1:0]  status_w, estatus_w, epc_w;
    logic [N_SRC-1:0] mask_w, pend_w;
    logic             any_pend_w;

    irq_pending #(.N_SRC(N_SRC)) u_pend (
        .lvl      (irq_lvl),
        .mask     (mask_w),
        .pend     (pend_w),
        .any_pend (any_pend_w)
    );

    // Boundary decision: only at a completed instruction, never on the
    // cycle the CPU is leaving a handler.
    assign exc_take = insn_done & status_w[GIE_BIT] & any_pend_w & ~eret;

    irq_regfile #(.N_SRC(N_SRC), .XLEN(XLEN)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (exc_take),
        .eret    (eret),
        .cur_pc  (cur_pc),
        .wr_en   (reg_we),
        .wr_sel  (reg_sel),
        .wr_data (reg_wdata),
        .status  (status_w),
        .estatus (estatus_w),
        .epc     (epc_w),
        .mask    (mask_w)
    );

    irq_rdmux #(.N_SRC(N_SRC), .XLEN(XLEN)) u_rd (
        .sel     (reg_sel),
        .status  (status_w),
        .estatus (estatus_w),
        .epc     (epc_w),
        .mask    (mask_w),
        .pend    (pend_w),
        .rdata   (reg_rdata)
    );

    assign exc_vector = HANDLER_ADDR;
    assign resume_pc  = epc_w;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned N_SRC = 32,
    parameter int unsigned XLEN  = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] irq_lvl,
    input logic             insn_done,
    input logic [XLEN-1:0]  cur_pc,
    input logic             eret,
    input logic             reg_we,
    input logic [SEL_W-1:0] reg_sel,
    input logic [XLEN-1:0]  reg_rdata,
    input logic             exc_take,
    input logic [XLEN-1:0]  status,
    input logic [XLEN-1:0]  estatus,
    input logic [XLEN-1:0]  epc,
    input logic [N_SRC-1:0] mask
);
    // R4
    take_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |-> (status[GIE_BIT] && ((irq_lvl & mask) != '0) && !eret));

    // R10
    no_take_midinsn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_done |-> !exc_take);

    // R6
    entry_gie_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |=> !status[GIE_BIT]);

    // R6
    entry_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |=> (estatus == $past(status)) && (epc == $past(cur_pc)));

    // R8
    eret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eret |=> status == $past(estatus));

    // R3
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_sel == SEL_MASK) |=> $stable(mask));

    // R2
    pend_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == SEL_PEND) |-> reg_rdata[N_SRC-1:0] == (irq_lvl & mask));
endmodule

bind irq_gate_ctrl irq_ctrl_chk #(.N_SRC(N_SRC), .XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_lvl   (irq_lvl),
    .insn_done (insn_done),
    .cur_pc    (cur_pc),
    .eret      (eret),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_rdata (reg_rdata),
    .exc_take  (exc_take),
    .status    (status_w),
    .estatus   (estatus_w),
    .epc       (epc_w),
    .mask      (mask_w)
);

// File: tb/tb_irq_gate_ctrl.sv
`timescale 1ns/1ps
module tb_irq_gate_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_lvl = '0;
    logic        insn_done = 1'b0;
    logic [31:0] cur_pc = '0;
    logic        eret = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        exc_take;
    logic [31:0] exc_vector;
    logic [31:0] resume_pc;

    irq_gate_ctrl dut (
        .clk(clk), .rst_n(rst_n), .irq_lvl(irq_lvl), .insn_done(insn_done),
        .cur_pc(cur_pc), .eret(eret), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .exc_take(exc_take),
        .exc_vector(exc_vector), .resume_pc(resume_pc)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    logic [31:0] m_status = '0, m_est = '0, m_epc = '0, m_mask = '0;
    string ev_tag = "R1";

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [2:0] sel, input logic [31:0] lvl);
        case (sel)
            3'd0: return m_status;
            3'd1: return m_est;
            3'd2: return m_mask;
            3'd3: return lvl & m_mask;
            3'd4: return m_epc;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string read_tag(input logic [2:0] sel);
        if (sel == 3'd3) return "R2";
        if (sel == 3'd2) return "R3";
        if (sel > 3'd4)  return "R9";
        return ev_tag;
    endfunction

    // Called at a falling edge; returns at the next falling edge.
    task automatic cyc(input logic [31:0] irq, input logic done, input logic [31:0] pc,
                       input logic er, input logic we, input logic [2:0] sel, input logic [31:0] wd);
        logic        e_take;
        logic [31:0] old_est;
        irq_lvl = irq; insn_done = done; cur_pc = pc; eret = er;
        reg_we = we; reg_sel = sel; reg_wdata = wd;
        #1;
        e_take = done & m_status[0] & ((irq & m_mask) != 0) & ~er;
        chk(exc_take == e_take, !done ? "R10" : (!m_status[0] ? "R7" : "R4"),
            {31'b0, exc_take}, {31'b0, e_take});
        chk(reg_rdata == exp_read(sel, irq), read_tag(sel), reg_rdata, exp_read(sel, irq));
        chk(resume_pc == m_epc, "R8", resume_pc, m_epc);
        chk(exc_vector == 32'h20, "R5", exc_vector, 32'h20);
        @(posedge clk);
        old_est = m_est;
        if (e_take) begin
            if (we && sel == 3'd2) m_mask = wd;
            m_est = m_status;
            m_status = m_status & ~32'h1;
            m_epc = pc;
            ev_tag = "R6";
        end else begin
            if (we) begin
                case (sel)
                    3'd0: m_status = wd;
                    3'd1: m_est = wd;
                    3'd2: m_mask = wd;
                    3'd4: m_epc = wd;
                    default: ;
                endcase
            end
            if (er) begin
                m_status = old_est;
                ev_tag = "R8";
            end else begin
                ev_tag = "R9";
            end
        end
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        int unsigned seed_set;
        seed_set = $urandom(32'h1F2E3D4C);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state, requests present but nothing enabled
        ev_tag = "R1";
        cyc('1, 1, 32'h100, 0, 0, 3'd0, 0);
        ev_tag = "R1";
        cyc('1, 1, 32'h104, 0, 0, 3'd1, 0);
        ev_tag = "R1";
        cyc('1, 1, 32'h108, 0, 0, 3'd2, 0);
        ev_tag = "R1";
        cyc('1, 1, 32'h10C, 0, 0, 3'd4, 0);

        // R3 mask write; R10 no take without boundary
        cyc(32'h0000_FF00, 0, 32'h200, 0, 1, 3'd2, 32'h0000_F0F0);
        // R2 pending read and ignored write
        cyc(32'h0000_FF00, 0, 32'h204, 0, 1, 3'd3, 32'hFFFF_FFFF);
        cyc(32'h0000_FF00, 0, 32'h208, 0, 0, 3'd2, 0);
        cyc(32'h0000_FF00, 0, 32'h20C, 0, 0, 3'd3, 0);
        // R9 unused select ignored
        cyc(32'h0, 0, 32'h210, 0, 1, 3'd5, 32'hDEAD_BEEF);
        cyc(32'h0, 0, 32'h214, 0, 0, 3'd5, 0);

        // R7 enable with a boundary in the same cycle: old enable is 0
        cyc(32'h0000_1000, 1, 32'h300, 0, 1, 3'd0, 32'h0000_0A01);
        // R6 take, colliding status write dropped
        cyc(32'h0000_1000, 1, 32'h304, 0, 1, 3'd0, 32'hFFFF_FFFF);
        cyc(32'h0000_1000, 0, 32'h400, 0, 0, 3'd0, 0);
        cyc(32'h0000_1000, 0, 32'h404, 0, 0, 3'd1, 0);
        cyc(32'h0000_1000, 0, 32'h408, 0, 0, 3'd4, 0);
        // R7 held pending while disabled
        for (int i = 0; i < 4; i++) cyc(32'h0000_3000, 1, 32'h410 + i, 0, 0, 3'd3, 0);
        // R8 eret beats status write; no take on eret cycle
        cyc(32'h0000_3000, 1, 32'h420, 1, 1, 3'd0, 32'h1234_0000);
        cyc(32'h0000_3000, 0, 32'h424, 0, 0, 3'd0, 0);
        cyc(32'h0000_3000, 1, 32'h428, 0, 0, 3'd1, 0);
        // Device drops request, re-enable via eret, no stale take
        cyc(32'h0, 0, 32'h500, 1, 0, 3'd0, 0);
        cyc(32'h0, 1, 32'h504, 0, 0, 3'd3, 0);
        // eret with pending and enable: no take (R4)
        cyc(32'h0000_0010, 0, 32'h508, 0, 1, 3'd2, 32'h0000_0010);
        cyc(32'h0000_0010, 1, 32'h50C, 1, 0, 3'd0, 0);

        // Constrained random
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] irq, pc, wd;
            logic done, er, we;
            logic [2:0] sel;
            irq  = $urandom & $urandom & $urandom;
            done = ($urandom % 3) != 0;
            er   = ($urandom % 12) == 0;
            we   = ($urandom % 5) == 0;
            sel  = 3'($urandom % 8);
            pc   = $urandom;
            wd   = $urandom;
            if (sel == 3'd0 && ($urandom % 4) != 0) wd[0] = 1'b1;
            cyc(irq, done, pc, er, we, sel, wd);
        end

        finish_run();
    end
endmodule